// File: doc/BRIEF.md
# Tolerant Windowed Sync Word Detector

This block sits in a packet receiver behind the preamble qualifier. When it is armed, it takes the demodulated bit stream one bit at a time. After each accepted bit it compares the newest N received bits with the low N bits of a 24-bit programmed pattern. N can be set from 1 to 24. The pattern is written as three bytes. The byte that arrives first sits in bits [23:16], and each byte is sent most significant bit first.

A match is accepted when the number of differing bits is no larger than a tolerance of 0 to 3. On a match the block pulses a found strobe and an optional interrupt. It then holds in payload-capture mode until the downstream capture logic reports that it has finished. The search lasts only a limited number of bits after arming: the sync length, plus the preamble tolerance in bits, plus a fixed margin of 16. If no match arrives within that window, the block pulses an expiry strobe and goes back to waiting for the preamble.

Top module: `sync_det`

## Requirements
- R1: After reset, hunt_o, capture_o, found_o, irq_o and expire_o are all 0.
- R2: arm_i while idle starts a search, and hunt_o is 1 in the next cycle. arm_i has no effect while searching or capturing.
- R3: When a bit is accepted during a search, the newest bit becomes bit 0 of the comparison and the earlier bits take the higher positions. If the count of positions i < N where the received bit differs from sync_pat_i[i] is at most the tolerance, found_o pulses for one cycle after that bit's edge. At the same time capture_o rises and hunt_o falls.
- R4: The tolerance is sync_ctrl_i[7:6]. The value 0 allows no differing bits, 1 allows one, 2 allows two and 3 allows three.
- R5: The sync length N is sync_ctrl_i[4:0]. A value of 0 is treated as 1, and a value above 24 is treated as 24.
- R6: No match is reported on the k-th accepted bit after arming when k < N.
- R7: The window is W = N + pre_tol_i + 16 bits. If the W-th accepted bit gives no match, expire_o pulses for one cycle and the block returns to idle. A match on the W-th bit wins over expiry.
- R8: irq_o pulses together with found_o only when irq_en_i is 1.
- R9: capture_o stays 1 until done_i is seen, and the block is idle in the following cycle.
- R10: Cycles with bit_vld_i low shift no bit, advance no window count, and raise neither found_o nor expire_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Preamble qualified, start a search |
| bit_vld_i | input | 1 | A received bit is present this cycle |
| bit_i | input | 1 | Received bit |
| sync_ctrl_i | input | 8 | [7:6] tolerance, [4:0] sync length |
| sync_pat_i | input | 24 | Sync pattern, first byte in [23:16] |
| pre_tol_i | input | PTOL_W (5) | Preamble tolerance in bits |
| irq_en_i | input | 1 | Interrupt mask |
| done_i | input | 1 | Payload capture finished |
| hunt_o | output | 1 | Searching for the sync word |
| capture_o | output | 1 | Payload capture mode |
| found_o | output | 1 | Sync matched, one-cycle pulse |
| irq_o | output | 1 | Masked interrupt pulse |
| expire_o | output | 1 | Window ended without a match, one-cycle pulse |

## Verification
The bench builds the block with its default parameters: a 24-bit pattern, a 5-bit preamble tolerance and a margin of 16. With these it sweeps sync lengths from 1 to 24 over every tolerance code and injects from 0 to 4 bit errors. This puts both sides of each tolerance boundary within reach: tolerance+1 errors must fail, and tolerance errors must pass. Long non-matching preludes drive the window to expiry. The out-of-range length codes 0 and 31 check the clamping. Idle gaps between bits, an arm during capture and the interrupt mask are exercised on the same runs.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_CAPT = 2'd2
  } sd_state_e;
endpackage

// File: rtl/sync_shreg.sv
module sync_shreg #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] q;

  assign nxt_o = {q[W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (clr_i)   q <= '0;
    else if (shift_i) q <= nxt_o;
  end
endmodule

// File: rtl/sync_cmp.sv
module sync_cmp #(
  parameter int W     = 24,
  parameter int LEN_W = 5
) (
  input  logic [W-1:0]     data_i,
  input  logic [W-1:0]     pat_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       tol_i,
  output logic             hit_o
);
  localparam int ERR_W = $clog2(W + 1);

  logic [W-1:0]     mask;
  logic [W-1:0]     diff;
  logic [ERR_W-1:0] errs;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (len_i > LEN_W'(i));
  end

  assign diff = (data_i ^ pat_i) & mask;

  always_comb begin
    errs = '0;
    for (int i = 0; i < W; i++) errs = errs + ERR_W'(diff[i]);
  end

  assign hit_o = (errs <= ERR_W'(tol_i));
endmodule

// File: rtl/sync_ctl.sv
module sync_ctl
  import sync_det_pkg::*;
#(
  parameter int LEN_W  = 5,
  parameter int PTOL_W = 5,
  parameter int WIN_W  = 7,
  parameter int MARGIN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              bit_vld_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PTOL_W-1:0] pre_tol_i,
  input  logic              cmp_hit_i,
  input  logic              irq_en_i,
  input  logic              done_i,
  output logic              clr_o,
  output logic              shift_o,
  output logic              hunt_o,
  output logic              capture_o,
  output logic              found_o,
  output logic              irq_o,
  output logic              expire_o
);
  sd_state_e        state_q, state_d;
  logic [WIN_W-1:0] cnt_q, cnt_d, k, win;
  logic             hit, timeout;

  assign win     = WIN_W'(len_i) + WIN_W'(pre_tol_i) + WIN_W'(MARGIN);
  assign k       = cnt_q + WIN_W'(1);
  assign shift_o = bit_vld_i && (state_q == ST_HUNT);
  assign clr_o   = arm_i && (state_q == ST_IDLE);
  // match needs N bits seen; match beats expiry on the last window bit
  assign hit     = shift_o && (k >= WIN_W'(len_i)) && cmp_hit_i;
  assign timeout = shift_o && !hit && (k == win);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (arm_i) begin
        state_d = ST_HUNT;
        cnt_d   = '0;
      end
      ST_HUNT: begin
        if (shift_o) cnt_d = k;
        if (hit)          state_d = ST_CAPT;
        else if (timeout) state_d = ST_IDLE;
      end
      ST_CAPT: if (done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      found_o  <= 1'b0;
      irq_o    <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      found_o  <= hit;
      irq_o    <= hit && irq_en_i;
      expire_o <= timeout;
    end
  end

  assign hunt_o    = (state_q == ST_HUNT);
  assign capture_o = (state_q == ST_CAPT);
endmodule

// File: rtl/sync_det.sv
module sync_det #(
  parameter int MAX_LEN = 24,
  parameter int PTOL_W  = 5,
  parameter int MARGIN  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic [7:0]        sync_ctrl_i,
  input  logic [MAX_LEN-1:0] sync_pat_i,
  input  logic [PTOL_W-1:0] pre_tol_i,
  input  logic              irq_en_i,
  input  logic              done_i,
  output logic              hunt_o,
  output logic              capture_o,
  output logic              found_o,
  output logic              irq_o,
  output logic              expire_o
);
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int WIN_MAX = MAX_LEN + (1 << PTOL_W) - 1 + MARGIN;
  localparam int WIN_W   = $clog2(WIN_MAX + 1);

  logic [LEN_W-1:0]   len_raw, len_eff;
  logic [1:0]         tol;
  logic [MAX_LEN-1:0] sh_nxt;
  logic               clr, shift, cmp_hit;

  assign len_raw = sync_ctrl_i[LEN_W-1:0];
  assign tol     = sync_ctrl_i[7:6];
  assign len_eff = (len_raw == '0)                   ? LEN_W'(1) :
                   (len_raw > LEN_W'(MAX_LEN))       ? LEN_W'(MAX_LEN) : len_raw;

  sync_shreg #(.W(MAX_LEN)) u_shreg (
    .clk_i, .rst_ni, .clr_i(clr), .shift_i(shift), .bit_i, .nxt_o(sh_nxt)
  );

  sync_cmp #(.W(MAX_LEN), .LEN_W(LEN_W)) u_cmp (
    .data_i(sh_nxt), .pat_i(sync_pat_i), .len_i(len_eff), .tol_i(tol), .hit_o(cmp_hit)
  );

  sync_ctl #(.LEN_W(LEN_W), .PTOL_W(PTOL_W), .WIN_W(WIN_W), .MARGIN(MARGIN)) u_ctl (
    .clk_i, .rst_ni, .arm_i, .bit_vld_i, .len_i(len_eff), .pre_tol_i,
    .cmp_hit_i(cmp_hit), .irq_en_i, .done_i,
    .clr_o(clr), .shift_o(shift), .hunt_o, .capture_o, .found_o, .irq_o, .expire_o
  );
endmodule

// File: rtl/sync_det_chk.sv
module sync_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_vld_i,
  input logic done_i,
  input logic hunt_o,
  input logic capture_o,
  input logic found_o,
  input logic irq_o,
  input logic expire_o
);
  // R3
  found_capt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> capture_o && !hunt_o);
  // R3
  found_from_hunt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> $past(hunt_o));
  // R7
  expire_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> !hunt_o && !capture_o && !found_o);
  // R8
  irq_found_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> found_o);
  // R9
  mode_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hunt_o, capture_o}));
  // R9
  capt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o && !done_i |=> capture_o);
  // R10
  idle_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(found_o) || $rose(expire_o) |-> $past(bit_vld_i));
endmodule

bind sync_det sync_det_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_vld_i(bit_vld_i), .done_i(done_i),
  .hunt_o(hunt_o), .capture_o(capture_o), .found_o(found_o),
  .irq_o(irq_o), .expire_o(expire_o)
);

// File: tb/sync_det_tb_top.sv
`timescale 1ns/1ps
module sync_det_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0;
  logic [7:0]  sync_ctrl_i = 8'h00;
  logic [23:0] sync_pat_i = '0;
  logic [4:0]  pre_tol_i = '0;
  logic        irq_en_i = 1'b0, done_i = 1'b0;
  logic        hunt_o, capture_o, found_o, irq_o, expire_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;

  sync_det dut_i (.*);

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(int len_f, int tol, int ptol, logic [23:0] pat,
                     int pre_n, int nerr, bit irq_en);
    int L, win, k, mm, n;
    logic [23:0] hist, mask;
    bit s[0:127];
    bit ef, ee;
    L    = (len_f == 0) ? 1 : (len_f > 24 ? 24 : len_f);
    win  = L + ptol + 16;
    mask = (L == 24) ? 24'hFFFFFF : ((24'd1 << L) - 24'd1);
    n = 0;
    for (int i = 0; i < pre_n; i++) s[n++] = bit'(i % 2);
    for (int j = 0; j < L; j++) s[n++] = pat[L-1-j] ^ (j < nerr);
    @(negedge clk_i);
    sync_ctrl_i = {tol[1:0], 1'b0, len_f[4:0]};
    sync_pat_i  = pat;
    pre_tol_i   = ptol[4:0];
    irq_en_i    = irq_en;
    arm_i = 1'b1;
    @(negedge clk_i);
    arm_i = 1'b0;
    chk("R2 hunt after arm", hunt_o, 1);
    hist = '0;
    for (int i = 0; i < 100; i++) begin
      k    = i + 1;
      bit_i = (i < n) ? s[i] : bit'(i % 2);
      hist = {hist[22:0], bit_i};
      mm   = $countones((hist ^ pat) & mask);
      ef   = (k >= L) && (mm <= tol);
      ee   = !ef && (k == win);
      bit_vld_i = 1'b1;
      @(negedge clk_i);
      bit_vld_i = 1'b0;
      chk("R3/R4/R5/R6 found", found_o, ef);
      chk("R7 expire", expire_o, ee);
      chk("R8 irq", irq_o, ef && irq_en);
      if (ef) begin
        chk("R3 capture", capture_o, 1);
        chk("R3 hunt low", hunt_o, 0);
        arm_i = 1'b1;
        @(negedge clk_i);
        arm_i = 1'b0;
        chk("R2 arm ignored in capture", capture_o, 1);
        chk("R9 held", capture_o, 1);
        done_i = 1'b1;
        @(negedge clk_i);
        done_i = 1'b0;
        chk("R9 idle after done", {capture_o, hunt_o}, 0);
        break;
      end
      if (ee) begin
        chk("R7 idle after expire", {capture_o, hunt_o}, 0);
        break;
      end
      if (i % 5 == 2) begin
        @(negedge clk_i);
        chk("R10 gap no event", {found_o, expire_o}, 0);
        chk("R10 still hunting", hunt_o, 1);
      end
    end
  endtask

  initial begin
    int lens[8] = '{1, 2, 5, 8, 13, 16, 20, 24};
    #1;
    chk("R1 reset outputs", {hunt_o, capture_o, found_o, irq_o, expire_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", {hunt_o, capture_o, found_o, irq_o, expire_o}, 0);
    foreach (lens[li]) begin
      for (int t = 0; t < 4; t++) begin
        for (int e = 0; e < 5; e++) begin
          if (e <= lens[li])
            run(lens[li], t, 2 * t, 24'hA73CD1 ^ 24'(lens[li] * 24'h010203), 7, e, bit'(t % 2));
        end
      end
    end
    run(0, 0, 0, 24'h000001, 4, 0, 1'b1);   // R5 length 0 as 1
    run(0, 0, 0, 24'h000001, 4, 1, 1'b1);
    run(31, 0, 3, 24'hC3A55A, 5, 0, 1'b1);  // R5 length 31 as 24
    run(31, 1, 3, 24'hC3A55A, 5, 2, 1'b0);
    run(16, 0, 0, 24'h00F0F0, 60, 0, 1'b1); // R7 expiry before pattern
    run(8, 0, 9, 24'h0000F3, 40, 0, 1'b0);  // R7 expiry with preamble tolerance
    summary();
  end
endmodule